// File: doc/BRIEF.md
# Endian-Aware Sub-Word Lane Unit

This unit sits between a load/store pipeline and a line of cached words. It is given one 32-bit word already read from the line, the size of the access, the two low address bits and the byte order in force. On a load it returns the addressed byte or halfword, right-aligned and zero-extended. On a store it returns the word with the addressed lane replaced by the new data. It also reports which half of the line the store has dirtied. Both the upper address bits and the line storage belong to the surrounding logic, which drops the two low bits to find the word. The unit keeps those two bits only to choose the lane.

Misaligned word and halfword accesses can raise a fault when the check is enabled. A faulted access returns zero on the load path, leaves the word unchanged and marks nothing dirty. The outputs can come straight from the logic or through one register stage that captures on a valid strobe. A build parameter selects between the two.

Top module: `subword_lane_unit`

## Requirements
- R1: With `align_chk` high, a word access (`size` 2'b10 or 2'b11) whose `addr_lo` is nonzero sets `align_fault`.
- R2: With `align_chk` high, a halfword access (`size` 2'b01) with `addr_lo[0]` set sets `align_fault`. A byte access (`size` 2'b00) never faults.
- R3: With `align_chk` low no access faults, and a halfword access then uses only `addr_lo[1]` to pick its lane, as if `addr_lo[0]` were zero.
- R4: A byte load returns in `rd_data[7:0]` the byte at bit position 8*a when `big_end` is low, or at 8*(3-a) when it is high, where a is `addr_lo`. Bits 31:8 are zero.
- R5: A halfword load with lane base h = `addr_lo` & 2 returns the 16 bits at offset 8*h when `big_end` is low, or at 8*(2-h) when it is high. Bits 31:16 are zero.
- R6: A word load returns `old_word` unchanged. Any faulted access returns zero on `rd_data`.
- R7: A byte or halfword store (`wr_en` high) puts the low 8 or 16 bits of `wr_data` into the lane chosen as in R4/R5 and keeps every other bit of `old_word`.
- R8: A word store sets `merged` to `wr_data`. With `wr_en` low, `merged` equals `old_word`.
- R9: A faulted store sets `merged` to `old_word` and raises neither dirty flag.
- R10: A non-faulted store raises `dirty_first` when `word_idx` is below half of `WORDS_PER_LINE`, and raises `dirty_last` otherwise. A load raises neither flag.
- R11: With `REG_OUT`=1, all results appear one clock after a cycle with `valid` high, together with `out_valid`. They hold while `valid` is low, and reset clears them to zero.
- R12: With `REG_OUT`=0, the results follow the inputs in the same cycle and `out_valid` equals `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Access present this cycle |
| size | input | 2 | 00 byte, 01 halfword, 1x word |
| addr_lo | input | 2 | Low address bits of the access |
| big_end | input | 1 | Big-endian byte order when high |
| align_chk | input | 1 | Enables the alignment fault |
| wr_en | input | 1 | Store when high, load when low |
| word_idx | input | IDX_W | Word position within the line |
| old_word | input | 32 | Current content of the addressed word |
| wr_data | input | 32 | Store data, right-aligned |
| out_valid | output | 1 | Results on the outputs are valid |
| rd_data | output | 32 | Extracted load data, zero-extended |
| merged | output | 32 | Word after the store merge |
| dirty_first | output | 1 | Store touched the first half of the line |
| dirty_last | output | 1 | Store touched the last half of the line |
| align_fault | output | 1 | Misaligned access detected |

## Verification
The bench builds two instances side by side and drives both with the same stimulus. The first uses the defaults of eight words per line and a registered output. This reaches the one-cycle latency, the hold-while-idle behaviour and the split between word indices 3 and 4. The second has sixteen words per line and no output register. This exposes the same-cycle path and moves the half-line boundary to indices 7 and 8, so a hard-coded boundary would give a wrong dirty flag.

// File: rtl/subword_lane_unit.sv
module subword_lane_unit #(
  parameter int WORDS_PER_LINE = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [1:0]       size,
  input  logic [1:0]       addr_lo,
  input  logic             big_end,
  input  logic             align_chk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] word_idx,
  input  logic [31:0]      old_word,
  input  logic [31:0]      wr_data,
  output logic             out_valid,
  output logic [31:0]      rd_data,
  output logic [31:0]      merged,
  output logic             dirty_first,
  output logic             dirty_last,
  output logic             align_fault
);

  localparam int HALF_WORDS = WORDS_PER_LINE / 2;

  logic        is_byte, is_half, is_word;
  logic        fault_c, store_ok, low_half;
  logic [1:0]  lane;
  logic [4:0]  sh;
  logic [31:0] lane_mask, shifted, wr_lane, rd_c, merged_c;

  assign is_byte = (size == 2'b00);
  assign is_half = (size == 2'b01);
  assign is_word = size[1];

  assign fault_c = align_chk & ((is_word & (|addr_lo)) | (is_half & addr_lo[0]));

  assign lane = is_half ? {big_end ^ addr_lo[1], 1'b0} : ({big_end, big_end} ^ addr_lo);
  assign sh   = {lane, 3'b000};

  assign lane_mask = (is_byte ? 32'h0000_00ff : 32'h0000_ffff) << sh;
  assign shifted   = old_word >> sh;
  assign wr_lane   = (is_byte ? {24'h0, wr_data[7:0]} : {16'h0, wr_data[15:0]}) << sh;

  always_comb begin
    if (fault_c)      rd_c = 32'h0;
    else if (is_word) rd_c = old_word;
    else if (is_half) rd_c = {16'h0, shifted[15:0]};
    else              rd_c = {24'h0, shifted[7:0]};
  end

  assign store_ok = wr_en & ~fault_c;
  assign low_half = (word_idx < IDX_W'(HALF_WORDS));

  always_comb begin
    if (!store_ok)    merged_c = old_word;
    else if (is_word) merged_c = wr_data;
    else              merged_c = (old_word & ~lane_mask) | wr_lane;
  end

  logic [1:0]  s_size;
  logic [31:0] s_old;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid   <= 1'b0;
          rd_data     <= '0;
          merged      <= '0;
          dirty_first <= 1'b0;
          dirty_last  <= 1'b0;
          align_fault <= 1'b0;
          s_size      <= 2'b00;
          s_old       <= '0;
        end else begin
          out_valid <= valid;
          if (valid) begin
            rd_data     <= rd_c;
            merged      <= merged_c;
            dirty_first <= store_ok & low_half;
            dirty_last  <= store_ok & ~low_half;
            align_fault <= fault_c;
            s_size      <= size;
            s_old       <= old_word;
          end
        end
      end

      a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> out_valid);
      a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (!out_valid && $stable(rd_data) && $stable(merged)));
    end else begin : g_comb
      assign out_valid   = valid;
      assign rd_data     = rd_c;
      assign merged      = merged_c;
      assign dirty_first = store_ok & low_half;
      assign dirty_last  = store_ok & ~low_half;
      assign align_fault = fault_c;
      assign s_size      = size;
      assign s_old       = old_word;
    end
  endgenerate

  a_r9_fault_no_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && align_fault) |-> (!dirty_first && !dirty_last));
  a_r9_fault_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && align_fault) |-> (merged == s_old));
  a_r10_one_half: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({dirty_first, dirty_last}) <= 1));
  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && s_size == 2'b00) |-> (rd_data[31:8] == 24'h0));
  a_r2_byte_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && s_size == 2'b00) |-> !align_fault);

endmodule

// File: tb/subword_lane_unit_tb_top.sv
`timescale 1ns/1ps
module subword_lane_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        valid = 0, big_end = 0, align_chk = 0, wr_en = 0;
  logic [1:0]  size = 0, addr_lo = 0;
  logic [2:0]  idx8 = 0;
  logic [3:0]  idx16 = 0;
  logic [31:0] old_word = 0, wr_data = 0;

  logic        ov_r, df_r, dl_r, af_r, ov_c, df_c, dl_c, af_c;
  logic [31:0] rd_r, mg_r, rd_c, mg_c;

  int checks = 0, errors = 0;

  subword_lane_unit #(.WORDS_PER_LINE(8), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid(valid), .size(size), .addr_lo(addr_lo),
    .big_end(big_end), .align_chk(align_chk), .wr_en(wr_en), .word_idx(idx8),
    .old_word(old_word), .wr_data(wr_data), .out_valid(ov_r), .rd_data(rd_r),
    .merged(mg_r), .dirty_first(df_r), .dirty_last(dl_r), .align_fault(af_r));

  subword_lane_unit #(.WORDS_PER_LINE(16), .REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .valid(valid), .size(size), .addr_lo(addr_lo),
    .big_end(big_end), .align_chk(align_chk), .wr_en(wr_en), .word_idx(idx16),
    .old_word(old_word), .wr_data(wr_data), .out_valid(ov_c), .rd_data(rd_c),
    .merged(mg_c), .dirty_first(df_c), .dirty_last(dl_c), .align_fault(af_c));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int bpos(input int a, input bit be);
    return be ? 3 - a : a;
  endfunction

  function automatic logic [7:0] getb(input logic [31:0] w, input int a, input bit be);
    return w[8*bpos(a, be) +: 8];
  endfunction

  function automatic logic [31:0] setb(input logic [31:0] w, input int a, input bit be, input logic [7:0] v);
    logic [31:0] r = w;
    r[8*bpos(a, be) +: 8] = v;
    return r;
  endfunction

  task automatic access(input string req, input logic [1:0] sz, input int a, input bit be,
                        input bit ac, input bit we, input int ix8, input int ix16,
                        input logic [31:0] ow, input logic [31:0] wd);
    bit flt;
    int h;
    logic [31:0] e_rd, e_mg;
    flt = ac && ((sz[1] && a != 0) || (sz == 2'b01 && a[0]));
    h = a & 2;
    if (sz == 2'b00) e_rd = {24'h0, getb(ow, a, be)};
    else if (sz == 2'b01)
      e_rd = be ? {16'h0, getb(ow, h, be), getb(ow, h+1, be)} : {16'h0, getb(ow, h+1, be), getb(ow, h, be)};
    else e_rd = ow;
    if (flt) e_rd = 0;
    e_mg = ow;
    if (we && !flt) begin
      if (sz == 2'b00) e_mg = setb(ow, a, be, wd[7:0]);
      else if (sz == 2'b01) begin
        e_mg = setb(ow, h, be, be ? wd[15:8] : wd[7:0]);
        e_mg = setb(e_mg, h+1, be, be ? wd[7:0] : wd[15:8]);
      end else e_mg = wd;
    end
    @(negedge clk);
    valid = 1; size = sz; addr_lo = a[1:0]; big_end = be; align_chk = ac; wr_en = we;
    idx8 = ix8[2:0]; idx16 = ix16[3:0]; old_word = ow; wr_data = wd;
    @(posedge clk); #1;
    chk(req, "reg out_valid", {31'h0, ov_r}, 32'd1);
    chk(req, "reg rd_data", rd_r, e_rd);
    chk(req, "reg merged", mg_r, e_mg);
    chk(req, "reg align_fault", {31'h0, af_r}, {31'h0, flt});
    chk(req, "reg dirty_first", {31'h0, df_r}, {31'h0, we && !flt && ix8 < 4});
    chk(req, "reg dirty_last", {31'h0, dl_r}, {31'h0, we && !flt && ix8 >= 4});
    chk(req, "comb rd_data", rd_c, e_rd);
    chk(req, "comb merged", mg_c, e_mg);
    chk(req, "comb align_fault", {31'h0, af_c}, {31'h0, flt});
    chk(req, "comb dirty_first", {31'h0, df_c}, {31'h0, we && !flt && ix16 < 8});
    chk(req, "comb dirty_last", {31'h0, dl_c}, {31'h0, we && !flt && ix16 >= 8});
  endtask

  task automatic t_reset();
    #1;
    chk("R11", "reset out_valid", {31'h0, ov_r}, 0);
    chk("R11", "reset rd_data", rd_r, 0);
    chk("R11", "reset merged", mg_r, 0);
    chk("R11", "reset dirty", {30'h0, df_r, dl_r}, 0);
  endtask

  task automatic t_byte_loads();
    for (int a = 0; a < 4; a++) begin
      access("R4", 2'b00, a, 0, 1, 0, 0, 0, 32'hA1B2C3D4, 0);
      access("R4", 2'b00, a, 1, 1, 0, 0, 0, 32'hA1B2C3D4, 0);
    end
  endtask

  task automatic t_half_loads();
    access("R5", 2'b01, 0, 0, 1, 0, 0, 0, 32'h1234ABCD, 0);
    access("R5", 2'b01, 2, 0, 1, 0, 0, 0, 32'h1234ABCD, 0);
    access("R5", 2'b01, 0, 1, 1, 0, 0, 0, 32'h1234ABCD, 0);
    access("R5", 2'b01, 2, 1, 1, 0, 0, 0, 32'h1234ABCD, 0);
    access("R6", 2'b10, 0, 1, 1, 0, 0, 0, 32'hCAFEF00D, 0);
    access("R6", 2'b11, 0, 0, 1, 0, 0, 0, 32'h0BADBEEF, 0);
  endtask

  task automatic t_stores();
    for (int a = 0; a < 4; a++) begin
      access("R7", 2'b00, a, 0, 1, 1, 1, 1, 32'h11223344, 32'hFFFF_FF5A);
      access("R7", 2'b00, a, 1, 1, 1, 5, 9, 32'h11223344, 32'hFFFF_FFA5);
    end
    access("R7", 2'b01, 2, 0, 1, 1, 2, 2, 32'h11223344, 32'hFFFF_BEEF);
    access("R7", 2'b01, 0, 1, 1, 1, 6, 12, 32'h11223344, 32'hFFFF_BEEF);
    access("R8", 2'b10, 0, 0, 1, 1, 7, 15, 32'h11223344, 32'hDEADBEEF);
    access("R8", 2'b10, 0, 0, 1, 0, 7, 15, 32'h11223344, 32'hDEADBEEF);
  endtask

  task automatic t_align();
    for (int a = 1; a < 4; a++) access("R1", 2'b10, a, 0, 1, 0, 0, 0, 32'h55AA55AA, 0);
    access("R2", 2'b01, 1, 0, 1, 0, 0, 0, 32'h55AA55AA, 0);
    access("R2", 2'b01, 3, 1, 1, 0, 0, 0, 32'h55AA55AA, 0);
    access("R2", 2'b00, 3, 0, 1, 0, 0, 0, 32'h55AA55AA, 0);
    access("R3", 2'b01, 3, 0, 0, 0, 0, 0, 32'h89ABCDEF, 0);
    access("R3", 2'b01, 1, 1, 0, 0, 0, 0, 32'h89ABCDEF, 0);
    access("R3", 2'b10, 2, 0, 0, 0, 0, 0, 32'h89ABCDEF, 0);
    access("R9", 2'b10, 1, 0, 1, 1, 0, 0, 32'h89ABCDEF, 32'h01234567);
    access("R9", 2'b01, 1, 1, 1, 1, 6, 10, 32'h89ABCDEF, 32'h01234567);
  endtask

  task automatic t_dirty();
    access("R10", 2'b10, 0, 0, 1, 1, 3, 7, 32'h0, 32'h1);
    access("R10", 2'b10, 0, 0, 1, 1, 4, 8, 32'h0, 32'h2);
    access("R10", 2'b00, 0, 0, 1, 0, 4, 8, 32'h0, 32'h3);
  endtask

  task automatic t_hold();
    logic [31:0] rd0, mg0;
    access("R11", 2'b10, 0, 0, 1, 1, 0, 0, 32'h0, 32'h77777777);
    rd0 = rd_r; mg0 = mg_r;
    @(negedge clk);
    valid = 0; old_word = 32'h12345678; wr_data = 32'h9; size = 2'b00;
    @(posedge clk); #1;
    chk("R11", "idle out_valid", {31'h0, ov_r}, 0);
    chk("R11", "idle rd_data held", rd_r, rd0);
    chk("R11", "idle merged held", mg_r, mg0);
    chk("R12", "comb out_valid", {31'h0, ov_c}, 0);
    chk("R12", "comb rd_data same cycle", rd_c, 32'h78);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_byte_loads();
    t_half_loads();
    t_stores();
    t_align();
    t_dirty();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule